// File: doc/BRIEF.md
# Alarm and Periodic Interrupt Controller

This block drives the interrupt line of a real-time clock. It has two kinds of source. Six periodic rates come from rollover strobes of the time counters: 100 Hz, 10 Hz, 1 Hz, once a minute, once an hour and once a day. The alarm source compares the live 51-bit time image against an alarm image that software loads over an 8-bit register bus. A control register enables each source. A status register names the source or sources that fired. Reading the status register clears every flag.

Each source has its own flag. The flag is set only when that source is enabled and its event occurs. The alarm event is a counter tick on which the live time equals the stored alarm time, so one match gives one event. In backup mode the bus is locked. Writes are dropped, reads return zero and do not clear anything, and flags keep being set and keep driving the interrupt line.

The register bus has no back-pressure. A write strobe takes effect at the clock edge on which it is sampled. Read data is valid during the cycle in which the read strobe is high. The read-clear of the status register takes effect at the end of that cycle. The rate strobes and the time tick are single-cycle pulses and are never stalled.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset the interrupt line is low and every register reads zero: status, control and all alarm bytes.
- R2: A rate strobe bit i (0=100 Hz, 1=10 Hz, 2=1 Hz, 3=minute, 4=hour, 5=day) whose control bit i is 1 sets status bit i and raises the interrupt line from the next cycle. Status bit 7 reads 1 whenever the interrupt line is high.
- R3: A rate strobe whose control bit is 0 sets no flag and leaves the interrupt line low.
- R4: The alarm image is written and read as bytes at addresses 0 to 6, least significant byte at address 0. Address 6 holds bits 50:48 in its bits 2:0, and its upper five bits always read 0.
- R5: With control bit 6 set, a cycle in which time_tick is high and time_now equals the alarm image sets status bit 6 and raises the interrupt line from the next cycle. A tick with a different time sets nothing.
- R6: The alarm fires only on a tick. Once cleared, the alarm flag stays clear while time_now keeps equal to the alarm image and no tick arrives.
- R7: A read of the status register (address 9) returns the flags and clears all of them. The interrupt line is low from the next cycle unless a new event occurs.
- R8: An enabled event that arrives in the same cycle as a status read is kept. It is not in the value read, but it is pending afterwards.
- R9: The interrupt line is high exactly while a flag is set whose control bit is 1. Clearing the control bit (control register at address 8) drops the line, and the flag still reads as set.
- R10: While bkup is high, bus writes change no register, and reads return 0 without clearing. Enabled events still set flags and drive the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bkup | input | 1 | Backup mode: bus access locked |
| rate_strb | input | 6 | Rollover strobes, 100 Hz to daily |
| time_now | input | 51 | Live time image from the counters |
| time_tick | input | 1 | High in the cycle time_now holds a new value |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, else 0 |
| irq | output | 1 | Interrupt, active high |

## Verification
Read data is combinational. It is due in the same cycle as the read strobe, so the bench drives the strobe after a falling edge and samples 1 ns later, before the rising edge that performs the clear. Flag updates and the interrupt line are due one rising edge after the strobe, tick or write that causes them. The bench therefore samples irq at the next falling edge. A status read made in the same cycle as an event must still show the flags from before that event.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int CTRL_ADDR = 8;
  localparam int STAT_ADDR = 9;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ALM,
    SEL_CTRL,
    SEL_STAT
  } rsel_e;
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
  parameter int ALM_W = 51,
  parameter int NSRC  = 7,
  parameter int AW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [7:0]                  wdata,
  output logic [((ALM_W+7)/8)*8-1:0]  alarm_bytes,
  output logic [NSRC-1:0]             ctrl
);
  import tmr_irq_pkg::*;
  localparam int NBYTE = (ALM_W + 7) / 8;
  localparam int PW    = NBYTE * 8;
  localparam logic [PW-1:0] KEEP = ~({PW{1'b1}} << ALM_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_bytes <= '0;
      ctrl        <= '0;
    end else if (we) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (addr == AW'(b))
          alarm_bytes[b*8 +: 8] <= wdata & KEEP[b*8 +: 8];
      end
      if (addr == AW'(CTRL_ADDR))
        ctrl <= wdata[NSRC-1:0];
    end
  end
endmodule

// File: rtl/tmr_irq_match.sv
module tmr_irq_match #(
  parameter int ALM_W = 51
) (
  input  logic [ALM_W-1:0] time_now,
  input  logic             time_tick,
  input  logic [ALM_W-1:0] alarm,
  output logic             hit
);
  logic same;

  assign same = (time_now == alarm);
  assign hit  = time_tick && same;
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  input  logic            clr,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] set_v;

  assign set_v = evt & en;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set_v;
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NRATE = 6,
  parameter int ALM_W = 51,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkup,
  input  logic [NRATE-1:0] rate_strb,
  input  logic [ALM_W-1:0] time_now,
  input  logic             time_tick,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  import tmr_irq_pkg::*;
  localparam int NSRC  = NRATE + 1;
  localparam int NBYTE = (ALM_W + 7) / 8;
  localparam int PW    = NBYTE * 8;

  logic            we, re;
  logic [PW-1:0]   alarm_bytes;
  logic [NSRC-1:0] ctrl;
  logic [NSRC-1:0] flags;
  logic            alm_hit;
  logic            stat_clr;
  rsel_e           sel;
  logic [7:0]      mux;

  assign we       = bus_wr && !bkup;
  assign re       = bus_rd && !bkup;
  assign stat_clr = re && (bus_addr == AW'(STAT_ADDR));

  tmr_irq_regs #(.ALM_W(ALM_W), .NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(bus_addr), .wdata(bus_wdata),
    .alarm_bytes(alarm_bytes), .ctrl(ctrl)
  );

  tmr_irq_match #(.ALM_W(ALM_W)) u_match (
    .time_now(time_now), .time_tick(time_tick),
    .alarm(alarm_bytes[ALM_W-1:0]), .hit(alm_hit)
  );

  tmr_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt({alm_hit, rate_strb}), .en(ctrl),
    .clr(stat_clr), .flags(flags), .irq(irq)
  );

  always_comb begin
    if (int'(bus_addr) < NBYTE)            sel = SEL_ALM;
    else if (bus_addr == AW'(CTRL_ADDR))   sel = SEL_CTRL;
    else if (bus_addr == AW'(STAT_ADDR))   sel = SEL_STAT;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    mux = '0;
    case (sel)
      SEL_ALM: begin
        for (int b = 0; b < NBYTE; b++)
          if (bus_addr == AW'(b)) mux = alarm_bytes[b*8 +: 8];
      end
      SEL_CTRL: mux = 8'(ctrl);
      SEL_STAT: mux = 8'({irq, flags});
      default:  mux = '0;
    endcase
  end

  assign bus_rdata = re ? mux : 8'h00;
endmodule

// File: rtl/tmr_irq_ctl_chk.sv
module tmr_irq_ctl_chk #(
  parameter int NRATE = 6,
  parameter int ALM_W = 51,
  parameter int AW    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bkup,
  input logic [NRATE-1:0]       rate_strb,
  input logic [ALM_W-1:0]       time_now,
  input logic                   time_tick,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic                   irq,
  input logic [NRATE:0]         ctrl,
  input logic [((ALM_W+7)/8)*8-1:0] alarm_bytes,
  input logic                   alm_hit
);
  import tmr_irq_pkg::*;
  logic ctrl_wr, rd_stat, ev_now, alm_eq_tick;

  assign ctrl_wr     = bus_wr && !bkup && (bus_addr == AW'(CTRL_ADDR));
  assign rd_stat     = bus_rd && !bkup && (bus_addr == AW'(STAT_ADDR));
  assign ev_now      = (|(rate_strb & ctrl[NRATE-1:0])) || (alm_hit && ctrl[NRATE]);
  assign alm_eq_tick = time_tick && (time_now == alarm_bytes[ALM_W-1:0]);

  // R2
  rate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rate_strb & ctrl[NRATE-1:0])) && !ctrl_wr |=> irq);

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !ev_now && !ctrl_wr |=> !irq);

  // R5
  alarm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_eq_tick && ctrl[NRATE] && !ctrl_wr |=> irq);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !ev_now |=> !irq);

  // R10
  bkup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkup && bus_wr |=> $stable(ctrl) && $stable(alarm_bytes));
endmodule

bind tmr_irq_ctl tmr_irq_ctl_chk #(.NRATE(NRATE), .ALM_W(ALM_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bkup(bkup), .rate_strb(rate_strb),
  .time_now(time_now), .time_tick(time_tick), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .irq(irq), .ctrl(ctrl),
  .alarm_bytes(alarm_bytes), .alm_hit(alm_hit)
);

// File: tb/tmr_irq_ctl_tb.sv
`timescale 1ns/1ps
module tmr_irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkup = 1'b0;
  logic [5:0]  rate_strb = '0;
  logic [50:0] time_now = '0;
  logic        time_tick = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;

  localparam logic [50:0] ALM = {3'b111, 48'h665544332211};

  always #2 clk = ~clk;

  tmr_irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bkup(bkup), .rate_strb(rate_strb),
    .time_now(time_now), .time_tick(time_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares read data against the scoreboard queue
  always @(smp_ev) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s rdata actual %02h expected %02h", t, bus_rdata, e);
    end
  end

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    exp_q.push_back(e); tag_q.push_back(t);
    ->smp_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic strobe(input logic [5:0] m);
    @(negedge clk);
    rate_strb = m;
    @(negedge clk);
    rate_strb = '0;
  endtask

  task automatic tick(input logic [50:0] t);
    @(negedge clk);
    time_now = t; time_tick = 1'b1;
    @(negedge clk);
    time_tick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 reset");
    rd(4'd9, 8'h00, "R1 status");
    rd(4'd8, 8'h00, "R1 ctrl");
    rd(4'd0, 8'h00, "R1 alarm byte0");

    wr(4'd8, 8'h01);
    strobe(6'h01);
    chk_irq(1'b1, "R2 100Hz");
    rd(4'd9, 8'h81, "R2 status");
    chk_irq(1'b0, "R7 cleared");
    rd(4'd9, 8'h00, "R7 status empty");

    strobe(6'h08);
    chk_irq(1'b0, "R3 masked");
    rd(4'd9, 8'h00, "R3 status");

    wr(4'd8, 8'h3F);
    strobe(6'h24);
    rd(4'd9, 8'hA4, "R2 two rates");

    strobe(6'h02);
    chk_irq(1'b1, "R9 set");
    wr(4'd8, 8'h00);
    chk_irq(1'b0, "R9 disabled");
    rd(4'd9, 8'h02, "R9 flag held");

    for (int i = 0; i < 6; i++) wr(4'(i), 8'(8'h11 * (i + 1)));
    wr(4'd6, 8'hFF);
    for (int i = 0; i < 6; i++) rd(4'(i), 8'(8'h11 * (i + 1)), "R4 alarm byte");
    rd(4'd6, 8'h07, "R4 top byte");

    wr(4'd8, 8'h40);
    tick(ALM ^ 51'd1);
    chk_irq(1'b0, "R5 no match");
    tick(ALM);
    chk_irq(1'b1, "R5 match");
    rd(4'd9, 8'hC0, "R5 status");
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R6 no refire");
    rd(4'd9, 8'h00, "R6 status");

    wr(4'd8, 8'h01);
    @(negedge clk);
    bus_addr = 4'd9; bus_rd = 1'b1; rate_strb = 6'h01;
    #1;
    exp_q.push_back(8'h00); tag_q.push_back("R8 read value");
    ->smp_ev;
    @(negedge clk);
    bus_rd = 1'b0; rate_strb = '0;
    chk_irq(1'b1, "R8 kept");
    rd(4'd9, 8'h81, "R8 status");

    bkup = 1'b1;
    wr(4'd8, 8'h00);
    rd(4'd8, 8'h00, "R10 read blocked");
    strobe(6'h01);
    chk_irq(1'b1, "R10 irq in backup");
    rd(4'd9, 8'h00, "R10 status blocked");
    chk_irq(1'b1, "R10 no clear");
    bkup = 1'b0;
    rd(4'd8, 8'h01, "R10 write ignored");
    rd(4'd9, 8'h81, "R10 status after");

    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule